// File: doc/BRIEF.md
# Address-Masked Atomic Data Port

This block holds the output data of an eight-pin I/O port and returns pin levels to software. Bits [9:2] of each bus address form a pin-select mask. A single access therefore changes or samples only the pins that the mask selects. Software can set or clear any group of pins in one access, with no read-modify-write sequence. Address offset 0x3FC selects every pin.

Accesses arrive on a valid/ready request channel. A read returns its data on a valid/ready response channel, and a write returns nothing. The response register holds one read result. While that result is waiting and the consumer holds `rsp_ready` low, `req_ready` stays low and no request is taken, whether read or write. A request counts as accepted on a clock edge where `req_valid` and `req_ready` are both high.

Pad levels pass through a two-flop synchroniser before any read can see them. For each pin, a direction bit picks what a read returns: the output register bit for an output pin, or the synchronised pad level for an input pin.

Top module: `gpio_masked_data_port`

## Requirements
- R1: After reset, `pin_out` is 0x00, `rsp_valid` is 0 and `rsp_rdata` is 0.
- R2: On an accepted write, `pin_out[k]` takes `req_wdata[k]` in the next cycle where `req_addr[2+k]` is 1. Where `req_addr[2+k]` is 0, `pin_out[k]` keeps its value whatever data is written.
- R3: An accepted read returns a response one cycle later. Its `rsp_rdata[7:0]` is the pin value ANDed with `req_addr[9:2]`, and `rsp_rdata[31:8]` is 0.
- R4: The pin value of pin k is `pin_out[k]` when `pin_dir[k]` is 1 (output), and the synchronised level of `pad_in[k]` when `pin_dir[k]` is 0 (input). `pin_dir` is sampled in the cycle the read is accepted.
- R5: Address 0x3FC writes all eight pins and returns all eight pin values on a read.
- R6: Suppose a pad level is set before clock edge n and held. A read accepted at edge n or n+1 still sees the old level. A read accepted at edge n+2 or later sees the new level.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0, and `rsp_rdata` and `rsp_valid` hold. A write presented during that time does not change `pin_out`.
- R8: Address bits [1:0] have no effect on any access.
- R9: A write produces no response, and `pin_out` changes only on an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset; bits [9:2] are the pin mask |
| req_wdata | input | 8 | Write data, one bit per pin |
| pin_dir | input | 8 | Per-pin direction, 1 = output |
| pad_in | input | 8 | Asynchronous pad levels |
| pin_out | output | 8 | Output data register |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data, bits [31:8] zero |

## Verification
The bench tests sparse, single-pin and empty masks. A design that used the data instead of the address as the mask would disturb pins outside the selection. A design that read the mask from the wrong address bits, or let bits [1:0] count, would return the wrong lanes. Mixed direction settings show whether each read lane takes the register bit or the pad level; a swapped select returns the wrong source. A pad change followed by reads on three consecutive edges checks the two-cycle synchroniser latency, which comes out too short or too long if a flop is missing or extra. A stalled response with a write waiting behind it shows whether a design drops data, overwrites the response or lets the write through.

// File: rtl/gpio_dp_pkg.sv
package gpio_dp_pkg;
  localparam int unsigned PINS      = 8;
  localparam int unsigned ADDR_W    = 10;
  localparam int unsigned MASK_LSB  = 2;
  localparam int unsigned RDATA_W   = 32;
  localparam int unsigned SYNC_LEN  = 2;

  typedef logic [PINS-1:0] pin_vec_t;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/gpio_dp_sync.sv
module gpio_dp_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  // One chain of STAGES flops per pin
  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_in[p]};
    end
    assign sync_out[p] = chain[STAGES-1];
  end
endmodule

// File: rtl/gpio_dp_mask_decode.sv
module gpio_dp_mask_decode #(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned MASK_LSB = 2,
  parameter int unsigned PINS     = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [PINS-1:0]   mask
);
  localparam int unsigned MASK_MSB = MASK_LSB + PINS - 1;

  // Low byte-offset bits carry no meaning for the port
  logic unused_low;
  assign unused_low = ^addr[MASK_LSB-1:0];

  for (genvar k = 0; k < PINS; k++) begin : g_bit
    assign mask[k] = addr[MASK_LSB + k];
  end

  if (MASK_MSB + 1 < ADDR_W) begin : g_high
    logic unused_high;
    assign unused_high = ^addr[ADDR_W-1:MASK_MSB+1];
  end
endmodule

// File: rtl/gpio_dp_out_reg.sv
module gpio_dp_out_reg #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PINS-1:0] wr_mask,
  input  logic [PINS-1:0] wr_data,
  output logic [PINS-1:0] q
);
  for (genvar k = 0; k < PINS; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                   q[k] <= 1'b0;
      else if (wr_en && wr_mask[k]) q[k] <= wr_data[k];
    end
  end
endmodule

// File: rtl/gpio_dp_rsp.sv
module gpio_dp_rsp #(
  parameter int unsigned PINS    = 8,
  parameter int unsigned RDATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [PINS-1:0]    load_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [RDATA_W-1:0] rsp_rdata,
  output logic               can_accept
);
  localparam int unsigned PAD_W = RDATA_W - PINS;

  assign can_accept = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= {{PAD_W{1'b0}}, load_data};
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_masked_data_port.sv
module gpio_masked_data_port
  import gpio_dp_pkg::*;
#(
  parameter int unsigned P_PINS     = PINS,
  parameter int unsigned P_ADDR_W   = ADDR_W,
  parameter int unsigned P_MASK_LSB = MASK_LSB,
  parameter int unsigned P_RDATA_W  = RDATA_W,
  parameter int unsigned P_SYNC     = SYNC_LEN
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [P_ADDR_W-1:0]  req_addr,
  input  logic [P_PINS-1:0]    req_wdata,
  input  logic [P_PINS-1:0]    pin_dir,
  input  logic [P_PINS-1:0]    pad_in,
  output logic [P_PINS-1:0]    pin_out,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [P_RDATA_W-1:0] rsp_rdata
);
  logic [P_PINS-1:0] acc_mask;
  logic [P_PINS-1:0] pad_sync;
  logic [P_PINS-1:0] pin_level;
  logic              accept;
  logic              wr_fire;
  logic              rd_fire;
  acc_kind_e         kind;

  assign kind    = acc_kind_e'(req_write);
  assign accept  = req_valid && req_ready;
  assign wr_fire = accept && (kind == ACC_WRITE);
  assign rd_fire = accept && (kind == ACC_READ);

  gpio_dp_mask_decode #(
    .ADDR_W(P_ADDR_W), .MASK_LSB(P_MASK_LSB), .PINS(P_PINS)
  ) u_dec (
    .addr(req_addr),
    .mask(acc_mask)
  );

  gpio_dp_sync #(
    .WIDTH(P_PINS), .STAGES(P_SYNC)
  ) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in(pad_in),
    .sync_out(pad_sync)
  );

  gpio_dp_out_reg #(
    .PINS(P_PINS)
  ) u_out (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_fire),
    .wr_mask(acc_mask),
    .wr_data(req_wdata),
    .q(pin_out)
  );

  // Per-pin source select: driven register for outputs, pad for inputs
  for (genvar k = 0; k < P_PINS; k++) begin : g_lvl
    assign pin_level[k] = pin_dir[k] ? pin_out[k] : pad_sync[k];
  end

  gpio_dp_rsp #(
    .PINS(P_PINS), .RDATA_W(P_RDATA_W)
  ) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .load(rd_fire),
    .load_data(pin_level & acc_mask),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata),
    .can_accept(req_ready)
  );
endmodule

// File: rtl/gpio_masked_data_port_chk.sv
module gpio_masked_data_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [9:0]  req_addr,
  input logic [7:0]  req_wdata,
  input logic [7:0]  pin_out,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata
);
  logic wr_acc;
  logic rd_acc;
  assign wr_acc = req_valid && req_ready && req_write;
  assign rd_acc = req_valid && req_ready && !req_write;

  // R2: pins outside the address mask keep their value across a write
  a_r2_unmasked_keep: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> ((pin_out & ~$past(req_addr[9:2])) ==
                ($past(pin_out) & ~$past(req_addr[9:2]))));

  // R2: selected pins take the written data
  a_r2_masked_take: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> ((pin_out & $past(req_addr[9:2])) ==
                ($past(req_wdata) & $past(req_addr[9:2]))));

  // R9: the output register changes only on an accepted write
  a_r9_no_stray_change: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_acc |=> $stable(pin_out));

  // R3: accepted read yields a response, upper bits zero, only masked lanes set
  a_r3_read_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> (rsp_valid && rsp_rdata[31:8] == 24'h0 &&
                (rsp_rdata[7:0] & ~$past(req_addr[9:2])) == 8'h00));

  // R7: stalled response holds and blocks requests
  a_r7_stall_block: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind gpio_masked_data_port gpio_masked_data_port_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .pin_out(pin_out),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
);

// File: tb/gpio_masked_data_port_bench.sv
module gpio_masked_data_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  pin_dir = '0;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pin_out;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_out = '0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_masked_data_port u_gpio_masked_data_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .pin_dir(pin_dir), .pad_in(pad_in), .pin_out(pin_out),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [7:0] model_write(logic [7:0] old, logic [7:0] m, logic [7:0] d);
    return (old & ~m) | (d & m);
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] drv, logic [7:0] dir,
                                             logic [7:0] pad, logic [7:0] m);
    return {24'h0, ((dir & drv) | (~dir & pad)) & m};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [9:0] a, logic [7:0] d, string req);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    exp_out = model_write(exp_out, a[9:2], d);
    check(req, {24'h0, pin_out}, {24'h0, exp_out});
  endtask

  task automatic do_read(logic [9:0] a, string req);
    logic [31:0] e;
    e = model_read(exp_out, pin_dir, pad_in, a[9:2]);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, {31'h0, rsp_valid}, 32'h1);
    check(req, rsp_rdata, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_out", {24'h0, pin_out}, 32'h0);
    check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check("R1 rsp_rdata", rsp_rdata, 32'h0);

    // R5 full-port write and read, all outputs
    pin_dir = 8'hFF;
    do_write(10'h3FC, 8'hA5, "R5 full write");
    do_read(10'h3FC, "R5 full read");

    // R2 sparse masked write, data tries to disturb all pins
    do_write({8'h0A, 2'b00}, 8'hFF, "R2 sparse write");
    do_write({8'h00, 2'b00}, 8'h00, "R2 empty mask write");
    do_write({8'h80, 2'b00}, 8'h00, "R2 single pin write");

    // R8 low address bits ignored
    do_write({8'h03, 2'b11}, 8'h02, "R8 write low bits");
    do_read({8'hF0, 2'b01}, "R8 read low bits");

    // R4 mixed direction
    pin_dir = 8'h0F; pad_in = 8'h6C;
    repeat (3) @(negedge clk);
    do_read(10'h3FC, "R4 mixed dir");
    do_read({8'h3C, 2'b00}, "R3 masked read");

    // R6 synchroniser latency: pad changes before edge n, reads at n, n+1, n+2
    pin_dir = 8'h00; pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'hFF;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 10'h3FC;
    @(negedge clk); check("R6 edge n", rsp_rdata, 32'h00);
    @(negedge clk); check("R6 edge n+1", rsp_rdata, 32'h00);
    @(negedge clk); check("R6 edge n+2", rsp_rdata, 32'hFF);
    req_valid = 1'b0;
    @(negedge clk);

    // R7 back-pressure: stalled response blocks a following write
    pin_dir = 8'hFF;
    rsp_ready = 1'b0;
    do_read(10'h3FC, "R7 stalled read");
    req_valid = 1'b1; req_write = 1'b1; req_addr = 10'h3FC; req_wdata = ~exp_out;
    repeat (2) @(negedge clk);
    check("R7 req_ready low", {31'h0, req_ready}, 32'h0);
    check("R7 write blocked", {24'h0, pin_out}, {24'h0, exp_out});
    check("R7 rsp held", rsp_rdata, {24'h0, exp_out});
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R9 rsp drained", {31'h0, rsp_valid}, 32'h0);
    do_write(10'h3FC, 8'h11, "R9 write");
    check("R9 no write response", {31'h0, rsp_valid}, 32'h0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [9:0] a;
      a = 10'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        pin_dir = 8'($urandom);
        pad_in  = 8'($urandom);
        repeat (3) @(negedge clk);
      end
      if ($urandom_range(0, 1) == 1) do_write(a, 8'($urandom), "R2 random write");
      else                           do_read(a, "R3 random read R4");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule